// File: doc/BRIEF.md
# SPI Inter-Transfer Gap Timer

This block sits next to an SPI master and decides when the next data word may begin. When the shifter reports that a word is complete, the timer loads a 15-bit gap length and counts that many idle ticks. Only then does it answer a pending start request from the transmit queue with a one-cycle grant. The shifter, the queues and any interrupt logic are outside this block.

The ticks that are counted come from one of two sources, chosen by a one-bit source select. The first is a one-cycle strobe marking each SPI bit clock, already in the bus clock domain. The second is a slow 32.768 kHz reference that arrives asynchronously; it is brought into the bus domain by a two-flop synchronizer followed by a rising-edge detector. When the slow reference paces the link, every grant falls on a reference tick. A word that cannot be granted on one tick therefore waits for a later tick. The gap length and the source select are sampled when a word completes, so a change made during a gap takes effect only at the next reload.

The control is a three-state machine:
- READY: no gap is pending, and a request may be granted.
- XFER: a word is in flight.
- GAP: idle ticks are being counted.

The transitions are:
- READY→XFER on a grant.
- XFER→READY on transfer-done with a zero gap.
- XFER→GAP on transfer-done with a non-zero gap.
- GAP→READY on the tick that brings the count to zero.

Top module: `spi_gap_timer`

## Requirements
- R1: After reset the state is READY with the bit-clock source, so `start_gnt` equals `start_req` combinationally.
- R2: With `cfg_src_slow`=0 and a gap N>0 loaded at `xfer_done`, `start_gnt` stays low until the N-th `bit_tick` after that cycle. It is high in the cycle just after the edge that samples that N-th tick, whatever the spacing of the ticks.
- R3: With a gap of 0 and the bit-clock source, `start_gnt` may be high in the very cycle after the `xfer_done` cycle, with no idle cycle between them.
- R4: `start_gnt` is never high without `start_req`. Once the gap has run out, the timer waits in READY for as long as needed and grants as soon as a request is present.
- R5: A grant lasts exactly one cycle. No further grant is given until the next `xfer_done`.
- R6: With `cfg_src_slow`=1, a rising edge on `ref_clk_in` becomes a one-cycle tick in the bus domain. That tick is high in the cycle after the second rising bus clock edge following the input edge. N ticks are counted, and the grant is given only during the (N+1)-th tick after `xfer_done`, never outside a tick cycle.
- R7: Changing `cfg_gap` or `cfg_src_slow` during a gap does not alter the count or the source in use. Both are sampled only at `xfer_done` (and the source also while in READY).
- R8: `xfer_done` outside XFER is ignored, so no gap is started from READY.
- R9: The largest gap, 0x7FFF, is counted in full with no early grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per SPI bit clock, bus domain |
| ref_clk_in | input | 1 | Asynchronous 32.768 kHz reference |
| cfg_gap | input | 15 | Number of idle ticks between words |
| cfg_src_slow | input | 1 | 1 = count reference ticks, 0 = count bit ticks |
| xfer_done | input | 1 | One-cycle pulse when a word has completed |
| start_req | input | 1 | Transmit queue holds a word to send |
| start_gnt | output | 1 | One-cycle permission for the shifter to begin |

## Verification
The bench sweeps gap lengths 0 to 6 against bit-tick spacings of one to three cycles. A design with an off-by-one count would grant one tick early or late. A design that waits a cycle after reaching zero would show an idle cycle in the zero-gap case. Slow-source runs count reference pulses and check that the grant lands only on the (N+1)-th tick. A design that ignored alignment would grant between ticks. Further runs change the configuration mid-gap, hold the request low past the end of a gap, pulse `xfer_done` while READY, and count the full 0x7FFF gap. These catch a counter that reloads live, a lost pending state, a spurious gap and a truncated counter.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_XFER  = 2'd1,
        ST_GAP   = 2'd2
    } gap_state_e;
endpackage

// File: rtl/ref_tick_sync.sv
module ref_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic ref_tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // stage 0 captures the asynchronous input; the rest shift it along
    generate
        for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= ref_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // rising edge of the synchronized level
    assign ref_tick = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/gap_fsm.sv
module gap_fsm
    import spi_gap_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic             cfg_src_slow,
    input  logic             xfer_done,
    input  logic             start_req,
    output logic             start_gnt,
    output gap_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             src_o,
    output logic             sel_tick_o
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    gap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             src_q, src_d;
    logic             sel_tick;
    logic             gnt;

    assign sel_tick = src_q ? ref_tick : bit_tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= CNT_ZERO;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            src_q   <= src_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        src_d   = src_q;
        unique case (state_q)
            ST_READY: begin
                src_d = cfg_src_slow;
                if (gnt) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (xfer_done) begin
                    src_d = cfg_src_slow;
                    if (cfg_gap == CNT_ZERO) begin
                        state_d = ST_READY;
                    end else begin
                        state_d = ST_GAP;
                        cnt_d   = cfg_gap;
                    end
                end
            end
            ST_GAP: begin
                if (sel_tick) begin
                    cnt_d = cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) state_d = ST_READY;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // outputs
    always_comb begin
        gnt        = (state_q == ST_READY) && start_req && (!src_q || ref_tick);
        start_gnt  = gnt;
        state_o    = state_q;
        cnt_o      = cnt_q;
        src_o      = src_q;
        sel_tick_o = sel_tick;
    end
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer
    import spi_gap_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             ref_clk_in,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic             cfg_src_slow,
    input  logic             xfer_done,
    input  logic             start_req,
    output logic             start_gnt
);
    logic             ref_tick_w;
    gap_state_e       state_w;
    logic [CNT_W-1:0] cnt_w;
    logic             src_w;
    logic             sel_tick_w;

    ref_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_async (ref_clk_in),
        .ref_tick  (ref_tick_w)
    );

    gap_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .ref_tick     (ref_tick_w),
        .cfg_gap      (cfg_gap),
        .cfg_src_slow (cfg_src_slow),
        .xfer_done    (xfer_done),
        .start_req    (start_req),
        .start_gnt    (start_gnt),
        .state_o      (state_w),
        .cnt_o        (cnt_w),
        .src_o        (src_w),
        .sel_tick_o   (sel_tick_w)
    );
endmodule

// File: rtl/spi_gap_checker.sv
module spi_gap_checker
    import spi_gap_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_req,
    input logic             start_gnt,
    input logic             xfer_done,
    input logic [CNT_W-1:0] cfg_gap,
    input logic             cfg_src_slow,
    input gap_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic             src,
    input logic             ref_tick,
    input logic             sel_tick
);
    p_gnt_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_gnt |-> start_req);

    p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_gnt |=> !start_gnt);

    p_slow_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_gnt && src) |-> ref_tick);

    p_zero_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && xfer_done && cfg_gap == '0 && !cfg_src_slow)
        |=> (state == ST_READY));

    p_load_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && xfer_done && cfg_gap != '0)
        |=> (state == ST_GAP && cnt == $past(cfg_gap)));

    p_hold_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && !sel_tick) |=> ($stable(cnt) && $stable(src)));

    p_done_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && !start_gnt) |=> (state == ST_READY));
endmodule

bind spi_gap_timer spi_gap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .start_gnt    (start_gnt),
    .xfer_done    (xfer_done),
    .cfg_gap      (cfg_gap),
    .cfg_src_slow (cfg_src_slow),
    .state        (state_w),
    .cnt          (cnt_w),
    .src          (src_w),
    .ref_tick     (ref_tick_w),
    .sel_tick     (sel_tick_w)
);

// File: tb/spi_gap_timer_bench.sv
module spi_gap_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 15;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_tick = 1'b0;
    logic             ref_clk_in = 1'b0;
    logic [CNT_W-1:0] cfg_gap = '0;
    logic             cfg_src_slow = 1'b0;
    logic             xfer_done = 1'b0;
    logic             start_req = 1'b0;
    logic             start_gnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_gap_timer #(.CNT_W(CNT_W)) u_spi_gap_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .ref_clk_in   (ref_clk_in),
        .cfg_gap      (cfg_gap),
        .cfg_src_slow (cfg_src_slow),
        .xfer_done    (xfer_done),
        .start_req    (start_req),
        .start_gnt    (start_gnt)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: start_gnt actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // from XFER: pulse done with the given gap and source; returns at the negedge after
    task automatic end_word(input int gap, input logic slow);
        cfg_gap      = CNT_W'(gap);
        cfg_src_slow = slow;
        xfer_done    = 1'b1;
        @(negedge clk);
        xfer_done    = 1'b0;
        #1;
    endtask

    // bit-clock gap of n ticks spaced s cycles; ends at the cycle the grant is seen
    task automatic run_bit(input int n, input int s);
        end_word(n, 1'b0);
        if (n == 0) begin
            chk("R3 zero gap back to back", start_gnt, 1'b1);
        end else begin
            for (int k = 1; k <= n; k++) begin
                for (int w = 1; w < s; w++) begin
                    chk("R2 no grant between ticks", start_gnt, 1'b0);
                    @(negedge clk); #1;
                end
                chk("R2 no grant before tick", start_gnt, 1'b0);
                bit_tick = 1'b1;
                @(negedge clk);
                bit_tick = 1'b0;
                #1;
                chk("R2 grant after Nth bit tick", start_gnt, (k == n));
            end
        end
        @(negedge clk); #1;
        chk("R5 no grant during transfer", start_gnt, 1'b0);
    endtask

    // one reference pulse; the tick is seen two rising edges after the raise
    task automatic ref_pulse(input logic exp_gnt);
        ref_clk_in = 1'b1;
        @(negedge clk); #1;
        chk("R6 no grant before sync tick", start_gnt, 1'b0);
        @(negedge clk); #1;
        chk("R6 grant only on (N+1)th ref tick", start_gnt, exp_gnt);
        ref_clk_in = 1'b0;
        @(negedge clk); #1;
        chk("R6 no grant after tick", start_gnt, 1'b0);
        @(negedge clk); #1;
    endtask

    initial begin
        int early;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset no request", start_gnt, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 idle after reset", start_gnt, 1'b0);
        start_req = 1'b1;
        #1;
        chk("R1 grant follows request", start_gnt, 1'b1);
        @(negedge clk); #1;
        chk("R5 grant lasts one cycle", start_gnt, 1'b0);

        // R2/R3 sweep: gaps 0..6, tick spacing 1..3
        for (int s = 1; s <= 3; s++) begin
            for (int n = 0; n <= 6; n++) begin
                run_bit(n, s);
            end
        end

        // R4: request absent when gap ends
        start_req = 1'b0;
        end_word(2, 1'b0);
        for (int k = 0; k < 2; k++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            #1;
            chk("R4 no grant without request", start_gnt, 1'b0);
        end
        repeat (5) @(negedge clk);
        #1;
        chk("R4 still waiting", start_gnt, 1'b0);
        start_req = 1'b1;
        #1;
        chk("R4 grant on late request", start_gnt, 1'b1);
        @(negedge clk); #1;

        // R7: configuration changed mid-gap
        end_word(3, 1'b0);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        cfg_gap = CNT_W'(1);
        cfg_src_slow = 1'b1;
        #1;
        chk("R7 after first tick", start_gnt, 1'b0);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        #1;
        chk("R7 new gap value not used", start_gnt, 1'b0);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        #1;
        chk("R7 old gap and source kept", start_gnt, 1'b1);
        cfg_src_slow = 1'b0;
        @(negedge clk); #1;

        // R8: done pulse while READY
        start_req = 1'b0;
        end_word(0, 1'b0);
        @(negedge clk);
        cfg_gap = CNT_W'(5);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        start_req = 1'b1;
        #1;
        chk("R8 done in READY ignored", start_gnt, 1'b1);
        @(negedge clk); #1;

        // R6: slow reference, gaps 0..4
        for (int n = 0; n <= 4; n++) begin
            end_word(n, 1'b1);
            for (int k = 1; k <= n + 1; k++) begin
                ref_pulse(k == n + 1);
            end
            chk("R5 no grant in transfer after slow grant", start_gnt, 1'b0);
        end

        // R6: bit ticks do not count in slow mode
        end_word(1, 1'b1);
        bit_tick = 1'b1;
        repeat (4) @(negedge clk);
        bit_tick = 1'b0;
        #1;
        chk("R6 bit ticks ignored in slow mode", start_gnt, 1'b0);
        ref_pulse(1'b0);
        ref_pulse(1'b1);

        // R9: largest gap
        early = 0;
        end_word(32767, 1'b0);
        bit_tick = 1'b1;
        for (int k = 1; k <= 32767; k++) begin
            @(negedge clk);
            if (k == 32767) bit_tick = 1'b0;
            #1;
            if (k < 32767 && start_gnt) early++;
        end
        n_checks++;
        if (early != 0) begin
            n_fail++;
            $display("FAIL R9 early grants actual=%0d expected=0", early);
        end
        chk("R9 grant after 0x7FFF ticks", start_gnt, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule